// File: doc/BRIEF.md
# Memory Command/Address Bus Decoder with Parity Alert

This block watches the command/address bus of a two-rank double-data-rate memory on every rising clock edge. It turns the sampled pins into a one-hot command word, plus the rank, bank group, bank, row and column fields that the command carries. It also produces the auto-precharge, all-bank-precharge and burst-chop qualifiers that travel on address lines 10 and 12. Two per-rank select lines pick the rank. A low activate strobe turns the three command strobes into the three top row-address bits.

A configuration input selects the narrow-device (x4, 17-bit row) or wide-device (x8, 16-bit row) addressing. A second configuration input enables an even parity check over the command and address pins. When the check fails, the decoded command is dropped and an active-low alert is held low for a fixed number of cycles. All decoded outputs appear one clock after the edge that sampled the bus.

Top module: `cmd_bus_decoder`

## Requirements
- R1: When both rank selects (`rank_sel_l[1:0]`) are sampled high, the cycle is a deselect: on the next cycle `cmd_onehot` is all zero and `illegal_o` is low.
- R2: With a rank select low and `activate_l` low, `cmd_onehot` bit 0 (activate) is set. `row_o` is {`row_strobe_l`, `col_strobe_l`, `wr_strobe_l`, `ca_addr[13:0]`}, with the strobes taking row bits 16, 15 and 14.
- R3: With a rank select low and `activate_l` high, the strobes {row, col, wr} decode as 101 = read (bit 1), 100 = write (bit 2), 010 = precharge (bit 3), 001 = refresh (bit 4), 000 = mode-register set (bit 5), 110 = ZQ calibration (bit 6), 111 = no operation (bit 7) and 011 = reserved (bit 8). At most one bit of `cmd_onehot` is ever set.
- R4: `auto_pre_o` is high exactly when a read or write is decoded with `ca_addr[10]` high.
- R5: `all_banks_o` is high exactly when a precharge is decoded with `ca_addr[10]` high. With `ca_addr[10]` low, the precharge targets the bank given by `group_o` and `bank_o`.
- R6: `chop_o` is high exactly when a read or write is decoded with `ca_addr[12]` low.
- R7: `col_o` is `ca_addr[9:0]`, `group_o` is `group_sel`, and `bank_o` is `bank_sel`. When `cfg_x8` is high, `row_o[16]` is forced to zero.
- R8: `rank_o` is 0 when `rank_sel_l[0]` is low and 1 when only `rank_sel_l[1]` is low. When both selects are low, `illegal_o` is set and `cmd_onehot` is zero.
- R9: The parity check runs when `cfg_par_en` is high and a rank select is low. The check fails when the XOR of `activate_l`, the three strobes, `ca_addr`, `bank_sel`, `group_sel` and `ca_parity` is 1. When `cfg_x8` is high during an activate, `row_strobe_l` counts as zero. When `cfg_par_en` is low, no error is ever raised.
- R10: A failed parity check drives `alert_l` low for ALERT_CYC cycles, starting on the cycle after the sampling edge, and it restarts the window. On that failed cycle `cmd_onehot` is zero.
- R11: While reset is held and after it, until the first sampled command, `cmd_onehot` is zero, `illegal_o` is low and `alert_l` is high. Decoded outputs follow the sampling edge by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_x8 | input | 1 | 1 = wide device, 16-bit row; 0 = narrow device, 17-bit row |
| cfg_par_en | input | 1 | Enables the command/address parity check |
| rank_sel_l | input | 2 | Active-low select for rank 0 and rank 1 |
| activate_l | input | 1 | Active-low activate strobe |
| row_strobe_l | input | 1 | Row strobe, or row bit 16 on activate |
| col_strobe_l | input | 1 | Column strobe, or row bit 15 on activate |
| wr_strobe_l | input | 1 | Write strobe, or row bit 14 on activate |
| ca_addr | input | 14 | Address lines 13..0 |
| bank_sel | input | 2 | Bank within the group |
| group_sel | input | 2 | Bank group |
| ca_parity | input | 1 | Even parity bit for the command/address bus |
| cmd_onehot | output | 9 | Registered one-hot command |
| rank_o | output | 1 | Decoded rank |
| group_o | output | 2 | Decoded bank group |
| bank_o | output | 2 | Decoded bank |
| row_o | output | 17 | Decoded row address |
| col_o | output | 10 | Decoded column address |
| auto_pre_o | output | 1 | Read/write with auto precharge |
| all_banks_o | output | 1 | Precharge applies to all banks |
| chop_o | output | 1 | Read/write with burst chop |
| illegal_o | output | 1 | Both rank selects were low |
| alert_l | output | 1 | Active-low parity alert |

## Verification
Random vectors mix the strobe codes, both addressing modes, both parity settings and both ranks, with about one vector in seven carrying a flipped parity bit. These vectors separate decode errors from field-routing errors and from parity-coverage errors. Directed cases cover the cycles that random traffic rarely reaches:
- every strobe code once;
- A10 and A12 at both levels on reads, writes and precharges;
- both selects low;
- a wide-mode activate with row bit 16 set, which exposes a missing mask in the parity tree;
- a clean run after one error, which measures the alert window;
- a second error inside the window, which shows that the window restarts.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;
  localparam int CMD_N = 9;

  typedef enum logic [3:0] {
    C_ACT = 4'd0, C_RD = 4'd1, C_WR = 4'd2, C_PRE = 4'd3, C_REF = 4'd4,
    C_MRS = 4'd5, C_ZQ = 4'd6, C_NOP = 4'd7, C_RSVD = 4'd8
  } cmd_e;

  // Strobe code to command index when the activate strobe is high
  function automatic cmd_e strobe_cmd(input logic r, input logic c, input logic w);
    case ({r, c, w})
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      3'b000:  return C_MRS;
      3'b110:  return C_ZQ;
      3'b111:  return C_NOP;
      default: return C_RSVD;
    endcase
  endfunction

  // Bit that is set in the one-hot command word for a given command index
  function automatic logic [CMD_N-1:0] one_hot(input cmd_e k);
    logic [CMD_N-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cmdec_decode.sv
module cmdec_decode
  import cmdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rank_sel_l,
  input  logic             activate_l,
  input  logic             row_strobe_l,
  input  logic             col_strobe_l,
  input  logic             wr_strobe_l,
  output logic [CMD_N-1:0] cmd_raw,
  output logic             selected,
  output logic             both_sel,
  output logic             rank
);
  assign selected = ~&rank_sel_l;
  assign both_sel = ~|rank_sel_l;
  assign rank     = rank_sel_l[0];

  always_comb begin
    cmd_raw = '0;
    if (selected && !both_sel) begin
      if (!activate_l) cmd_raw = one_hot(C_ACT);
      else             cmd_raw = one_hot(strobe_cmd(row_strobe_l, col_strobe_l, wr_strobe_l));
    end
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_raw)); // R3
  AST_BOTH_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    both_sel |-> (cmd_raw == '0)); // R8
endmodule

// File: rtl/cmdec_parity.sv
module cmdec_parity #(
  parameter int ADDR_W  = 14,
  parameter int BANK_W  = 2,
  parameter int GROUP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_x8,
  input  logic               cfg_par_en,
  input  logic               selected,
  input  logic               activate_l,
  input  logic               row_strobe_l,
  input  logic               col_strobe_l,
  input  logic               wr_strobe_l,
  input  logic [ADDR_W-1:0]  ca_addr,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic [GROUP_W-1:0] group_sel,
  input  logic               ca_parity,
  output logic               par_err
);
  localparam int COV_W = 4 + ADDR_W + BANK_W + GROUP_W + 1;

  logic             top_row_unused;
  logic [COV_W-1:0] covered;
  logic             odd;

  // Row bit 16 is not an address in wide mode during an activate: count it as zero
  assign top_row_unused = cfg_x8 & ~activate_l;
  assign covered = {activate_l, row_strobe_l & ~top_row_unused, col_strobe_l,
                    wr_strobe_l, ca_addr, bank_sel, group_sel, ca_parity};
  assign odd     = ^covered;
  assign par_err = cfg_par_en & selected & odd;

  AST_PAR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_par_en |-> !par_err); // R9
  AST_PAR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> !par_err); // R9
endmodule

// File: rtl/cmdec_alert.sv
module cmdec_alert #(
  parameter int ALERT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic par_err,
  output logic alert_l
);
  localparam int CNT_W = $clog2(ALERT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (par_err)      cnt_q <= CNT_W'(ALERT_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign alert_l = (cnt_q == '0);

  AST_ALERT_FOLLOWS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !alert_l); // R10
  AST_ALERT_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alert_l) == 1'b1) |-> !$past(par_err)); // R10
endmodule

// File: rtl/cmd_bus_decoder.sv
module cmd_bus_decoder
  import cmdec_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int BANK_W    = 2,
  parameter int GROUP_W   = 2,
  parameter int COL_W     = 10,
  parameter int ALERT_CYC = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_x8,
  input  logic                    cfg_par_en,
  input  logic [1:0]              rank_sel_l,
  input  logic                    activate_l,
  input  logic                    row_strobe_l,
  input  logic                    col_strobe_l,
  input  logic                    wr_strobe_l,
  input  logic [ADDR_W-1:0]       ca_addr,
  input  logic [BANK_W-1:0]       bank_sel,
  input  logic [GROUP_W-1:0]      group_sel,
  input  logic                    ca_parity,
  output logic [CMD_N-1:0]        cmd_onehot,
  output logic                    rank_o,
  output logic [GROUP_W-1:0]      group_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [ADDR_W+2:0]       row_o,
  output logic [COL_W-1:0]        col_o,
  output logic                    auto_pre_o,
  output logic                    all_banks_o,
  output logic                    chop_o,
  output logic                    illegal_o,
  output logic                    alert_l
);
  localparam int ROW_W  = ADDR_W + 3;
  localparam int AP_BIT = 10;
  localparam int BC_BIT = 12;

  logic [CMD_N-1:0] cmd_raw, cmd_next;
  logic             selected, both_sel, rank_now, par_err;
  logic [ROW_W-1:0] row_next;
  logic             is_rdwr, is_pre;

  cmdec_decode u_decode (
    .clk(clk), .rst_n(rst_n), .rank_sel_l(rank_sel_l), .activate_l(activate_l),
    .row_strobe_l(row_strobe_l), .col_strobe_l(col_strobe_l), .wr_strobe_l(wr_strobe_l),
    .cmd_raw(cmd_raw), .selected(selected), .both_sel(both_sel), .rank(rank_now)
  );

  cmdec_parity #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .GROUP_W(GROUP_W)) u_parity (
    .clk(clk), .rst_n(rst_n), .cfg_x8(cfg_x8), .cfg_par_en(cfg_par_en),
    .selected(selected), .activate_l(activate_l), .row_strobe_l(row_strobe_l),
    .col_strobe_l(col_strobe_l), .wr_strobe_l(wr_strobe_l), .ca_addr(ca_addr),
    .bank_sel(bank_sel), .group_sel(group_sel), .ca_parity(ca_parity), .par_err(par_err)
  );

  cmdec_alert #(.ALERT_CYC(ALERT_CYC)) u_alert (
    .clk(clk), .rst_n(rst_n), .par_err(par_err), .alert_l(alert_l)
  );

  // A command that fails parity is dropped
  assign cmd_next = par_err ? '0 : cmd_raw;
  assign is_rdwr  = cmd_next[C_RD] | cmd_next[C_WR];
  assign is_pre   = cmd_next[C_PRE];
  assign row_next = {row_strobe_l & ~cfg_x8, col_strobe_l, wr_strobe_l, ca_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_onehot  <= '0;
      rank_o      <= 1'b0;
      group_o     <= '0;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      all_banks_o <= 1'b0;
      chop_o      <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      cmd_onehot  <= cmd_next;
      rank_o      <= rank_now;
      group_o     <= group_sel;
      bank_o      <= bank_sel;
      row_o       <= row_next;
      col_o       <= ca_addr[COL_W-1:0];
      auto_pre_o  <= is_rdwr & ca_addr[AP_BIT];
      all_banks_o <= is_pre & ca_addr[AP_BIT];
      chop_o      <= is_rdwr & ~ca_addr[BC_BIT];
      illegal_o   <= both_sel;
    end
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&rank_sel_l) |=> (cmd_onehot == '0 && !illegal_o)); // R1
  AST_AP_ONLY_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_o |-> (cmd_onehot[C_RD] || cmd_onehot[C_WR])); // R4
  AST_ALLBANK_ONLY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    all_banks_o |-> cmd_onehot[C_PRE]); // R5
  AST_CHOP_ONLY_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    chop_o |-> (cmd_onehot[C_RD] || cmd_onehot[C_WR])); // R6
  AST_ROW_TOP_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_x8 |=> (row_o[ROW_W-1] == 1'b0)); // R7
  AST_PARERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> (cmd_onehot == '0)); // R10
  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (cmd_onehot == '0)); // R8
endmodule

// File: tb/cmd_bus_decoder_tb.sv
`timescale 1ns/1ps
module cmd_bus_decoder_tb;
  localparam int ALERT_CYC = 6;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_x8 = 1'b0, cfg_par_en = 1'b0;
  logic [1:0]  rank_sel_l = 2'b11;
  logic        activate_l = 1'b1, row_strobe_l = 1'b1, col_strobe_l = 1'b1, wr_strobe_l = 1'b1;
  logic [13:0] ca_addr = '0;
  logic [1:0]  bank_sel = '0, group_sel = '0;
  logic        ca_parity = 1'b0;
  logic [8:0]  cmd_onehot;
  logic        rank_o, auto_pre_o, all_banks_o, chop_o, illegal_o, alert_l;
  logic [1:0]  group_o, bank_o;
  logic [16:0] row_o;
  logic [9:0]  col_o;

  int n_chk = 0, n_bad = 0, alert_left = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_bus_decoder #(.ALERT_CYC(ALERT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_x8(cfg_x8), .cfg_par_en(cfg_par_en),
    .rank_sel_l(rank_sel_l), .activate_l(activate_l), .row_strobe_l(row_strobe_l),
    .col_strobe_l(col_strobe_l), .wr_strobe_l(wr_strobe_l), .ca_addr(ca_addr),
    .bank_sel(bank_sel), .group_sel(group_sel), .ca_parity(ca_parity),
    .cmd_onehot(cmd_onehot), .rank_o(rank_o), .group_o(group_o), .bank_o(bank_o),
    .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o), .all_banks_o(all_banks_o),
    .chop_o(chop_o), .illegal_o(illegal_o), .alert_l(alert_l)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected command index from the requirement tables (9 = none)
  function automatic int exp_cmd_idx(input logic a, input logic r, input logic c, input logic w);
    if (!a) return 0;
    if (r && !c && w)  return 1;
    if (r && !c && !w) return 2;
    if (!r && c && !w) return 3;
    if (!r && !c && w) return 4;
    if (!r && !c && !w) return 5;
    if (r && c && !w)  return 6;
    if (r && c && w)   return 7;
    return 8;
  endfunction

  // Parity bit that makes the covered set even
  function automatic logic good_parity(input logic a, input logic r, input logic c, input logic w,
                                       input logic [13:0] ad, input logic [1:0] b, input logic [1:0] g);
    logic r_eff;
    r_eff = (cfg_x8 && !a) ? 1'b0 : r;
    return logic'($countones({a, r_eff, c, w, ad, b, g}) % 2);
  endfunction

  task automatic apply(input logic [1:0] s, input logic a, input logic r, input logic c,
                       input logic w, input logic [13:0] ad, input logic [1:0] b,
                       input logic [1:0] g, input logic flip);
    bit sel, both, err;
    int k;
    logic [8:0] exp_cmd;
    string ctag;
    rank_sel_l = s; activate_l = a; row_strobe_l = r; col_strobe_l = c; wr_strobe_l = w;
    ca_addr = ad; bank_sel = b; group_sel = g;
    ca_parity = good_parity(a, r, c, w, ad, b, g) ^ flip;
    sel  = (s != 2'b11);
    both = (s == 2'b00);
    err  = cfg_par_en && sel && flip;
    k    = (sel && !both && !err) ? exp_cmd_idx(a, r, c, w) : 9;
    exp_cmd = (k == 9) ? 9'd0 : (9'd1 << k);
    ctag = !sel ? "R1" : both ? "R8" : err ? "R10" : (k == 0) ? "R2" : "R3";
    @(posedge clk);
    if (err) alert_left = ALERT_CYC;
    else if (alert_left > 0) alert_left--;
    @(negedge clk);
    check(ctag, "cmd_onehot", 32'(cmd_onehot), 32'(exp_cmd));
    check("R8", "illegal", 32'(illegal_o), 32'(both));
    check("R10", "alert_l", 32'(alert_l), 32'(alert_left == 0));
    if (sel && !both) check("R8", "rank", 32'(rank_o), 32'(s[0]));
    if (k == 0) check("R2", "row", 32'(row_o), 32'({r & ~cfg_x8, c, w, ad}));
    if (k == 1 || k == 2) begin
      check("R7", "col", 32'(col_o), 32'(ad[9:0]));
      check("R4", "auto_pre", 32'(auto_pre_o), 32'(ad[10]));
      check("R6", "chop", 32'(chop_o), 32'(!ad[12]));
    end else begin
      check("R4", "auto_pre idle", 32'(auto_pre_o), 32'(0));
      check("R6", "chop idle", 32'(chop_o), 32'(0));
    end
    check("R5", "all_banks", 32'(all_banks_o), 32'(k == 3 && ad[10]));
    if (k <= 3) begin
      check("R7", "group", 32'(group_o), 32'(g));
      check("R7", "bank", 32'(bank_o), 32'(b));
    end
  endtask

  task automatic cmd(input logic [2:0] rcw, input logic [13:0] ad);
    apply(2'b10, 1'b1, rcw[2], rcw[1], rcw[0], ad, 2'd2, 2'd1, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "cmd in reset", 32'(cmd_onehot), 32'(0));
    check("R11", "alert in reset", 32'(alert_l), 32'(1));
    check("R11", "illegal in reset", 32'(illegal_o), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "cmd after reset", 32'(cmd_onehot), 32'(0));

    // R1 deselect, R3 each strobe code, R4/R6 qualifiers
    apply(2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0400, 2'd0, 2'd0, 1'b0);
    for (int i = 0; i < 8; i++) cmd(3'(i), 14'(i * 14'h0a55));
    cmd(3'b101, 14'h0400); cmd(3'b101, 14'h1000); cmd(3'b100, 14'h0000); cmd(3'b100, 14'h1400);
    // R5 single and all-bank precharge
    cmd(3'b010, 14'h0000); cmd(3'b010, 14'h0400);
    // R8 ranks and illegal
    apply(2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0123, 2'd3, 2'd3, 1'b0);
    apply(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0123, 2'd3, 2'd3, 1'b0);
    // R2/R7 activate in both widths with top row bit set
    apply(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 14'h3fff, 2'd1, 2'd2, 1'b0);
    cfg_x8 = 1'b1;
    apply(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 14'h2aaa, 2'd1, 2'd2, 1'b0);
    // R9: wide-mode activate with bit 16 set under parity, must stay clean
    cfg_par_en = 1'b1;
    apply(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 14'h1111, 2'd3, 2'd0, 1'b0);
    cfg_x8 = 1'b0;
    apply(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 14'h1111, 2'd3, 2'd0, 1'b0);
    // R10: one error, then a clean run that spans the whole window
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0055, 2'd0, 2'd1, 1'b1);
    for (int i = 0; i < ALERT_CYC + 2; i++) cmd(3'b111, 14'h0000);
    // R10: restart inside the window
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0001, 2'd0, 2'd1, 1'b1);
    repeat (3) cmd(3'b111, 14'h0000);
    apply(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0002, 2'd0, 2'd1, 1'b1);
    for (int i = 0; i < ALERT_CYC + 1; i++) cmd(3'b111, 14'h0000);
    // R9: flipped parity ignored when disabled
    cfg_par_en = 1'b0;
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0777, 2'd2, 2'd2, 1'b1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] s;
      int pick;
      if (i % 200 == 0) begin
        cfg_x8 = 1'($urandom);
        cfg_par_en = 1'($urandom);
      end
      pick = int'($urandom_range(0, 19));
      s = (pick == 0) ? 2'b11 : (pick == 1) ? 2'b00 : (pick < 11) ? 2'b10 : 2'b01;
      apply(s, 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
            14'($urandom), 2'($urandom), 2'($urandom), 1'($urandom_range(0, 6) == 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule